// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is an SPI target that lets an off-chip host read and write a 32-bit internal register space one word at a time. Each chip-select-framed transaction begins with a 24-bit header, always sent most-significant bit first. The header's top bit marks a write when set and a read when clear, and its remaining 23 bits are a word address. A write then carries one 32-bit payload. A read carries a programmable number of dummy bytes and then returns one 32-bit payload. Payloads use the byte order and bit order the host has selected.

SPI mode 0 is used. MOSI is sampled on rising SCLK, and MISO changes on falling SCLK. SCLK, chip select and MOSI reach the system clock through synchronisers, so SCLK has to be several system clocks per half period. Two word addresses at `LOCAL_BASE` belong to the bridge itself:
- **Format register** (`LOCAL_BASE`): holds the payload format.
- **Config/status register** (`LOCAL_BASE+1`): holds the dummy-byte count, the late-data flag and the interface code.

Every other address is forwarded on a valid/ready register bus. `bus_valid` rises with address, write flag and write data. All of these hold steady until the cycle in which `bus_ready` is also high; the bridge then drops `bus_valid` and, for a read, captures `bus_rdata` in that same cycle. The bus side may stall for any number of cycles. Back-pressure only narrows the time left before read data is due.

Top module: `spi_reg_bridge`

## Requirements
- R1: After reset, the format code is 0 (byte order least-significant byte first, bit order MSB first) and the dummy-byte count is 0.
- R2: When the header's top bit is 1, the 32 bits that follow are written as one word to the 23-bit word address in the low header bits. Non-local addresses are written on the register bus with `bus_we` high.
- R3: The header is decoded MSB first whatever payload format is active.
- R4: Format code bit 0 selects the payload byte order on the wire: 1 sends `[31:24]` first, 0 sends `[7:0]` first. Bit 1 selects the bit order within each byte: 1 sends bit 0 of the byte first, 0 sends bit 7 first. Write payloads and read payloads both use this format.
- R5: A write to the format register takes its new code from data bits 1:0. Each byte of the host's data must carry code bit 0 at byte bits 0 and 7 and code bit 1 at byte bits 1 and 6. With that layout the write decodes correctly under any of the four active formats.
- R6: Reading the format register returns the current code in that same replicated byte layout.
- R7: The config/status register holds the dummy-byte count in bits 3:0, the late-data flag in bit 16, and the interface code (parameter, default 2) in bits 31:24. A write loads bits 3:0.
- R8: On a read, exactly `8*count` SCLK cycles follow the header before the first data bit. MOSI is ignored during those cycles.
- R9: The late-data flag sets when read data is not yet available at the falling SCLK edge where the first data bit must be driven. In that case the payload returns as zeros. The flag stays set until the config/status register is written.
- R10: If chip select rises before a write payload is complete, nothing is written, neither on the bus nor in the local registers.
- R11: Once `bus_valid` is high, it and `bus_addr`, `bus_we` and `bus_wdata` hold steady until the cycle `bus_ready` is high.
- R12: Reset returns the format and dummy-byte settings to their defaults after the host has changed them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| bus_valid | output | 1 | Register bus request valid |
| bus_ready | input | 1 | Register bus accepts the request |
| bus_addr | output | 23 | Register bus word address |
| bus_we | output | 1 | Register bus write flag |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data, sampled with ready |

## Verification
The bench builds the bridge with two-stage synchronisers, `LOCAL_BASE` of 0 and interface code 2. It drives SCLK at sixteen system clocks per bit. Its bus model answers after 40 cycles. That latency is longer than the half bit that a zero-dummy read allows, and far shorter than one dummy byte. Both outcomes of the late-data flag can therefore be reached, along with the flag's sticky clearing and the zero payload it causes.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int DATA_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int NBYTES    = DATA_W / BYTE_W;
  localparam int HDR_W     = 24;
  localparam int WADDR_W   = HDR_W - 1;
  localparam int PAD_W     = 4;
  localparam int FMT_W     = 2;
  localparam int IFNUM_W   = 8;
  localparam int IFNUM_LSB = 24;
  localparam int ERR_BIT   = 16;
  localparam int MAX_BITS  = HDR_W + ((1 << PAD_W) - 1) * BYTE_W + DATA_W;
  localparam int CNT_W     = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {PH_HDR, PH_WR, PH_RD, PH_END} phase_e;

  // Wire-order word <-> register word. The mapping is its own inverse.
  function automatic logic [DATA_W-1:0] fmt_map(input logic [DATA_W-1:0] v,
                                                input logic [FMT_W-1:0] code);
    logic [DATA_W-1:0] r;
    logic [BYTE_W-1:0] b;
    logic [BYTE_W-1:0] rb;
    r = '0;
    for (int k = 0; k < NBYTES; k++) begin
      b = v[DATA_W-1-k*BYTE_W -: BYTE_W];
      for (int j = 0; j < BYTE_W; j++) rb[j] = b[BYTE_W-1-j];
      if (code[1]) b = rb;
      if (code[0]) r[DATA_W-1-k*BYTE_W -: BYTE_W] = b;
      else         r[k*BYTE_W +: BYTE_W] = b;
    end
    return r;
  endfunction

  // Format code laid out so that any byte or bit order decodes it the same way.
  function automatic logic [DATA_W-1:0] fmt_word(input logic [FMT_W-1:0] code);
    logic [BYTE_W-1:0] p;
    p = '0;
    p[0] = code[0];
    p[1] = code[1];
    p[BYTE_W-2] = code[1];
    p[BYTE_W-1] = code[0];
    return {NBYTES{p}};
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{INIT[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_rb_link.sv
module spi_rb_link
  import spi_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_idle,
  input  logic              mosi_s,
  input  logic              load_tx,
  input  logic [DATA_W-1:0] tx_word,
  output logic              miso,
  output logic              bit_done,
  output logic              fall_evt,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              sclk_q;
  logic              rise_evt;
  logic [DATA_W-1:0] tx_q;

  assign rise_evt = sclk_s & ~sclk_q & ~cs_idle;
  assign fall_evt = ~sclk_s & sclk_q & ~cs_idle;
  assign miso     = tx_q[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      bit_done <= 1'b0;
      bit_cnt  <= '0;
      rx_word  <= '0;
      tx_q     <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (cs_idle) begin
        bit_done <= 1'b0;
        bit_cnt  <= '0;
        tx_q     <= '0;
      end else begin
        bit_done <= rise_evt;
        if (rise_evt) begin
          rx_word <= {rx_word[DATA_W-2:0], mosi_s};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (fall_evt) begin
          if (load_tx) tx_q <= tx_word;
          else         tx_q <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_rb_busm.sv
module spi_rb_busm
  import spi_rb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [WADDR_W-1:0] l_addr,
  input  logic               l_we,
  input  logic [DATA_W-1:0]  l_wdata,
  output logic               bus_valid,
  input  logic               bus_ready,
  output logic [WADDR_W-1:0] bus_addr,
  output logic               bus_we,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_data
);
  logic accept;
  assign accept = bus_valid & bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
      rd_done   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_done <= 1'b0;
      if (accept) begin
        bus_valid <= 1'b0;
        if (!bus_we) begin
          rd_done <= 1'b1;
          rd_data <= bus_rdata;
        end
      end
      if (launch && (!bus_valid || accept)) begin
        bus_valid <= 1'b1;
        bus_addr  <= l_addr;
        bus_we    <= l_we;
        bus_wdata <= l_wdata;
      end
    end
  end
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
  import spi_rb_pkg::*;
#(
  parameter logic [WADDR_W-1:0] LOCAL_BASE = '0,
  parameter logic [IFNUM_W-1:0] IF_CODE    = 8'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_idle,
  input  logic               bit_done,
  input  logic               fall_evt,
  input  logic [CNT_W-1:0]   bit_cnt,
  input  logic [DATA_W-1:0]  rx_word,
  input  logic               rd_done,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               load_tx,
  output logic [DATA_W-1:0]  tx_word,
  output logic               launch,
  output logic [WADDR_W-1:0] l_addr,
  output logic               l_we,
  output logic [DATA_W-1:0]  l_wdata,
  output logic [FMT_W-1:0]   fmt_q,
  output logic               err_q,
  output logic               wr_evt
);
  localparam logic [CNT_W-1:0] HDR_DONE = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] WR_DONE  = CNT_W'(HDR_W + DATA_W);

  phase_e             phase;
  logic [WADDR_W-1:0] hdr_addr;
  logic               is_local;
  logic               sel_cfg;
  logic               rd_rdy;
  logic [DATA_W-1:0]  rd_buf;
  logic [PAD_W-1:0]   pad_q;

  logic               hdr_fire, wr_fire;
  logic               hdr_we_now, local_now, cfg_now;
  logic [WADDR_W-1:0] hdr_addr_now;
  logic [CNT_W-1:0]   deadline;
  logic [DATA_W-1:0]  wdata_dec;
  logic [DATA_W-1:0]  cfg_word;

  assign hdr_addr_now = rx_word[WADDR_W-1:0];
  assign hdr_we_now   = rx_word[HDR_W-1];
  assign cfg_now      = (hdr_addr_now == LOCAL_BASE + WADDR_W'(1));
  assign local_now    = (hdr_addr_now == LOCAL_BASE) || cfg_now;

  assign hdr_fire = bit_done && !cs_idle && (phase == PH_HDR) && (bit_cnt == HDR_DONE);
  assign wr_fire  = bit_done && !cs_idle && (phase == PH_WR) && (bit_cnt == WR_DONE);

  assign deadline  = HDR_DONE + CNT_W'(pad_q) * CNT_W'(BYTE_W);
  assign load_tx   = fall_evt && (phase == PH_RD) && (bit_cnt == deadline);
  assign tx_word   = rd_rdy ? fmt_map(rd_buf, fmt_q) : '0;
  assign wdata_dec = fmt_map(rx_word, fmt_q);

  always_comb begin
    cfg_word = '0;
    cfg_word[IFNUM_LSB +: IFNUM_W] = IF_CODE;
    cfg_word[ERR_BIT]              = err_q;
    cfg_word[PAD_W-1:0]            = pad_q;
  end

  assign launch  = (hdr_fire && !hdr_we_now && !local_now) || (wr_fire && !is_local);
  assign l_addr  = hdr_fire ? hdr_addr_now : hdr_addr;
  assign l_we    = wr_fire;
  assign l_wdata = wdata_dec;
  assign wr_evt  = wr_fire && is_local;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HDR;
      hdr_addr <= '0;
      is_local <= 1'b0;
      sel_cfg  <= 1'b0;
      rd_rdy   <= 1'b0;
      rd_buf   <= '0;
      fmt_q    <= '0;
      pad_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (rd_done && phase == PH_RD && !rd_rdy) begin
        rd_rdy <= 1'b1;
        rd_buf <= rd_data;
      end
      if (cs_idle) begin
        phase  <= PH_HDR;
        rd_rdy <= 1'b0;
      end else begin
        if (hdr_fire) begin
          hdr_addr <= hdr_addr_now;
          is_local <= local_now;
          sel_cfg  <= cfg_now;
          phase    <= hdr_we_now ? PH_WR : PH_RD;
          rd_rdy   <= local_now;
          rd_buf   <= cfg_now ? cfg_word : fmt_word(fmt_q);
        end
        if (wr_fire) begin
          phase <= PH_END;
          if (is_local) begin
            if (sel_cfg) begin
              pad_q <= wdata_dec[PAD_W-1:0];
              err_q <= 1'b0;
            end else begin
              fmt_q <= wdata_dec[FMT_W-1:0];
            end
          end
        end
        if (load_tx && !rd_rdy) err_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_rb_pkg::*;
#(
  parameter int                 SYNC_STAGES = 2,
  parameter logic [WADDR_W-1:0] LOCAL_BASE  = '0,
  parameter logic [IFNUM_W-1:0] IF_CODE     = 8'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sclk,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               bus_valid,
  input  logic               bus_ready,
  output logic [WADDR_W-1:0] bus_addr,
  output logic               bus_we,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata
);
  logic [2:0]         pins_s;
  logic               cs_idle, sclk_s, mosi_s;
  logic               bit_done, fall_evt, load_tx;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  rx_word, tx_word;
  logic               launch, l_we, rd_done, err_q, wr_evt;
  logic [WADDR_W-1:0] l_addr;
  logic [DATA_W-1:0]  l_wdata, rd_data;
  logic [FMT_W-1:0]   fmt_q;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}),
    .q(pins_s)
  );
  assign cs_idle = pins_s[2];
  assign sclk_s  = pins_s[1];
  assign mosi_s  = pins_s[0];

  spi_rb_link link_i (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_idle(cs_idle), .mosi_s(mosi_s),
    .load_tx(load_tx), .tx_word(tx_word), .miso(spi_miso), .bit_done(bit_done),
    .fall_evt(fall_evt), .bit_cnt(bit_cnt), .rx_word(rx_word)
  );

  spi_rb_ctrl #(.LOCAL_BASE(LOCAL_BASE), .IF_CODE(IF_CODE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .bit_done(bit_done),
    .fall_evt(fall_evt), .bit_cnt(bit_cnt), .rx_word(rx_word), .rd_done(rd_done),
    .rd_data(rd_data), .load_tx(load_tx), .tx_word(tx_word), .launch(launch),
    .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata), .fmt_q(fmt_q),
    .err_q(err_q), .wr_evt(wr_evt)
  );

  spi_rb_busm busm_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .l_addr(l_addr), .l_we(l_we),
    .l_wdata(l_wdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_done(rd_done), .rd_data(rd_data)
  );
endmodule

// File: rtl/spi_rb_chk.sv
module spi_rb_chk
  import spi_rb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_ready,
  input logic [WADDR_W-1:0] bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               cs_idle,
  input logic               load_tx,
  input logic               err_q,
  input logic [FMT_W-1:0]   fmt_q,
  input logic               wr_evt,
  input logic               spi_miso
);
  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R10
  wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) && bus_we |-> $past(!cs_idle));

  // R9
  late_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(load_tx));

  // R5
  fmt_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fmt_q) |-> $past(wr_evt));

  // R8
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_idle) |-> !spi_miso);
endmodule

bind spi_reg_bridge spi_rb_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .cs_idle(cs_idle),
  .load_tx(load_tx), .err_q(err_q), .fmt_q(fmt_q), .wr_evt(wr_evt), .spi_miso(spi_miso)
);

// File: tb/spi_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_reg_bridge_tb_top;
  localparam int HALF    = 8;
  localparam int BUS_LAT = 40;
  localparam logic [22:0] FMT_A = 23'h0;
  localparam logic [22:0] CFG_A = 23'h1;
  localparam logic [22:0] BUS_A = 23'h100;
  // {format code, data word}
  localparam logic [33:0] VEC [8] = '{
    34'h1_A1B2C3D4, 34'h3_0F1E2D3C, 34'h2_80000001, 34'h0_DEADBEEF,
    34'h3_12345678, 34'h1_FFFF0000, 34'h0_00C3A500, 34'h2_5A5A0F0F };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, bus_valid, bus_ready, bus_we;
  logic [22:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int n_checks = 0, n_fail = 0;
  logic [1:0] cur_fmt = 2'd0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  spi_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // register bus model with fixed latency
  logic [31:0] mem [16];
  logic [22:0] last_addr;
  int lat_cnt, wr_count;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0; bus_rdata <= '0; lat_cnt <= 0; wr_count <= 0; last_addr <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      bus_ready <= 1'b0;
      if (bus_valid && !bus_ready) begin
        if (lat_cnt == BUS_LAT - 1) begin
          lat_cnt   <= 0;
          bus_ready <= 1'b1;
          last_addr <= bus_addr;
          if (bus_we) begin
            mem[bus_addr[3:0]] <= bus_wdata;
            wr_count <= wr_count + 1;
          end else bus_rdata <= mem[bus_addr[3:0]];
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] to_wire(input logic [31:0] w, input logic [1:0] c);
    logic [31:0] r;
    int k, j, wb, bb;
    for (int i = 0; i < 32; i++) begin
      k = i / 8; j = i % 8;
      wb = c[0] ? 3 - k : k;
      bb = c[1] ? j : 7 - j;
      r[31-i] = w[8*wb + bb];
    end
    return r;
  endfunction

  function automatic logic [31:0] pat(input logic [1:0] c);
    logic [7:0] p;
    p = {c[0], c[1], 4'b0000, c[1], c[0]};
    return {4{p}};
  endfunction

  task automatic spi_frame(input logic [23:0] hdr, input bit is_wr, input logic [31:0] wtx,
                           input int pad, input int stop_at, output logic [31:0] wrx);
    int total;
    logic b;
    total = is_wr ? 56 : 24 + 8*pad + 32;
    wrx = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      if (stop_at != 0 && i == stop_at) break;
      if (i < 24) b = hdr[23-i];
      else if (is_wr) b = wtx[31-(i-24)];
      else if (i < 24 + 8*pad) b = 1'b1;
      else b = 1'b0;
      mosi = b;
      repeat (HALF) @(negedge clk);
      if (!is_wr && i >= 24 + 8*pad) wrx = {wrx[30:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
    while (bus_valid) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [22:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    spi_frame({1'b1, a}, 1'b1, to_wire(d, cur_fmt), 0, 0, dummy);
  endtask

  task automatic reg_rd(input logic [22:0] a, input int pad, output logic [31:0] w);
    spi_frame({1'b0, a}, 1'b0, '0, pad, 0, w);
  endtask

  task automatic set_fmt(input logic [1:0] c);
    reg_wr(FMT_A, pat(c));
    cur_fmt = c;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    int cnt0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 R7: reset values
    reg_rd(CFG_A, 0, w); check("R1 R7 cfg after reset", w, to_wire(32'h0200_0000, 2'd0));
    reg_rd(FMT_A, 0, w); check("R1 R6 fmt after reset", w, 32'h0);

    // R7: dummy count write
    reg_wr(CFG_A, 32'h0000_0001);
    reg_rd(CFG_A, 1, w); check("R7 cfg pad=1", w, to_wire(32'h0200_0001, 2'd0));

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      set_fmt(VEC[i][33:32]);
      reg_rd(FMT_A, 1, w); check("R5 R6 fmt readback", w, to_wire(pat(cur_fmt), cur_fmt));
      reg_wr(BUS_A + 23'(i), VEC[i][31:0]);
      check("R2 R3 bus addr", {9'd0, last_addr}, {9'd0, BUS_A + 23'(i)});
      check("R4 write decode", mem[i], VEC[i][31:0]);
      reg_rd(BUS_A + 23'(i), 1, w); check("R4 read encode", w, to_wire(VEC[i][31:0], cur_fmt));
    end

    // R8: three dummy bytes of ones are ignored
    set_fmt(2'd0);
    reg_wr(CFG_A, 32'h3);
    cnt0 = wr_count;
    reg_rd(BUS_A + 23'd3, 3, w); check("R8 data after 3 dummy bytes", w, to_wire(VEC[3][31:0], 2'd0));
    check("R8 no write during dummies", 32'(wr_count), 32'(cnt0));
    reg_rd(CFG_A, 3, w); check("R8 R9 no late flag", w, to_wire(32'h0200_0003, 2'd0));

    // R9: too few dummies
    reg_wr(CFG_A, 32'h0);
    reg_rd(BUS_A, 0, w); check("R9 late read returns zero", w, 32'h0);
    reg_rd(CFG_A, 0, w); check("R9 flag set", w, to_wire(32'h0201_0000, 2'd0));
    reg_rd(FMT_A, 0, w);
    reg_rd(CFG_A, 0, w); check("R9 flag sticky", w, to_wire(32'h0201_0000, 2'd0));
    reg_wr(CFG_A, 32'h2);
    reg_rd(CFG_A, 2, w); check("R9 flag cleared by write", w, to_wire(32'h0200_0002, 2'd0));
    reg_rd(BUS_A, 2, w); check("R9 timely read", w, to_wire(VEC[0][31:0], 2'd0));
    reg_rd(CFG_A, 2, w); check("R9 flag stays clear", w, to_wire(32'h0200_0002, 2'd0));

    // R10: aborted writes
    cnt0 = wr_count;
    spi_frame({1'b1, BUS_A + 23'd5}, 1'b1, to_wire(32'h1111_2222, cur_fmt), 0, 40, w);
    check("R10 no bus write", 32'(wr_count), 32'(cnt0));
    check("R10 mem unchanged", mem[5], VEC[5][31:0]);
    spi_frame({1'b1, FMT_A}, 1'b1, to_wire(pat(2'd3), cur_fmt), 0, 50, w);
    reg_rd(FMT_A, 2, w); check("R10 fmt unchanged", w, to_wire(pat(2'd0), 2'd0));

    // R12: reset restores defaults
    set_fmt(2'd3);
    reg_wr(CFG_A, 32'h5);
    @(negedge clk); rst_n = 1'b0;
    repeat (5) @(negedge clk); rst_n = 1'b1;
    repeat (10) @(negedge clk);
    cur_fmt = 2'd0;
    reg_rd(FMT_A, 0, w); check("R12 fmt default", w, 32'h0);
    reg_rd(CFG_A, 0, w); check("R12 cfg default", w, to_wire(32'h0200_0000, 2'd0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule